// File: doc/BRIEF.md
# Masked Widening Float Subtract Lane

This block is the arithmetic lane of a vector unit for one widening subtract form. For each destination element it takes a single-precision minuend from the wide source, widens the half-precision subtrahend to single precision without loss, and subtracts it using the dynamic rounding mode. It walks the destination register group one element per clock, from index 0 up to the element capacity, so the tail is covered as well as the body.

A start pulse latches the vector length, capacity, mask-enable bit, the mask bits, both policy bits and the rounding mode. The lane then presents an element index on its read port and expects the register file to return the three operands for that index in the same cycle: wide source, narrow source and current destination value. One cycle later it emits a write of the finished element. Each element is either computed, left at its old value, or set to all ones, depending on its mask bit and the policy bits. A done pulse follows the last write. Exception flags are gathered over computed elements only.

Top module: `wsub_lane`

## Requirements
- R1: Each computed element equals the wide operand minus the widened narrow operand, never the reverse (1.0 − 2.0 gives 0xBF800000).
- R2: Widening half to single is exact for normal, subnormal, zero and infinite halves and raises no flag (subnormal half 0x0001 becomes 2^-24).
- R3: With vm_i=1 every element with index below vl is computed; with vm_i=0 only those whose bit in v0_i (bit i for element i) is 1.
- R4: A masked-off element below vl is written with its old value when vma_i=0 and with 0xFFFFFFFF when vma_i=1.
- R5: An element at index ≥ vl is written with its old value when vta_i=0 and with 0xFFFFFFFF when vta_i=1.
- R6: Rounding follows frm_i encoded 0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest-away; a tie such as 2^24 − 0.5 gives 0x4B800000 under 0, 3 and 4 and 0x4B7FFFFF under 1 and 2.
- R7: Every NaN result is 0x7FC00000; a signalling NaN in either operand, or a subtraction of equal-signed infinities, raises the invalid flag; a quiet NaN alone raises nothing.
- R8: A non-zero exact cancellation gives −0 under mode 2 and +0 otherwise; −0 minus +0 gives −0 in every mode.
- R9: A result beyond the largest finite value raises overflow and inexact and yields infinity or 0x7F7FFFFF (with sign) according to the rounding direction.
- R10: fflags_o holds invalid at bit 3, overflow at bit 2, underflow at bit 1, inexact at bit 0; it is cleared by start and ORs in the flags of computed elements only.
- R11: After an accepted start, index k is written in the k+2nd cycle, indices ascend from 0 to VLMAX−1, done_o pulses for one cycle right after the last write, and a start while an operation is running is ignored together with any change of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| vl_i | input | CNT_W | Vector length |
| vlmax_i | input | CNT_W | Element capacity of the destination group |
| vm_i | input | 1 | 1 = unmasked, 0 = use v0_i |
| v0_i | input | MAX_ELEMS | Mask bits, bit i for element i |
| vta_i | input | 1 | Tail policy, 1 = write all ones |
| vma_i | input | 1 | Masked-off policy, 1 = write all ones |
| frm_i | input | 3 | Rounding mode |
| rd_idx_o | output | IDX_W | Element index whose operands are requested |
| rd_vld_o | output | 1 | Read index valid |
| vs2_i | input | 32 | Wide minuend for rd_idx_o |
| vs1_i | input | 16 | Narrow subtrahend for rd_idx_o |
| vd_old_i | input | 32 | Current destination value for rd_idx_o |
| wr_en_o | output | 1 | Element write strobe |
| wr_idx_o | output | IDX_W | Element write index |
| wr_data_o | output | 32 | Element write value |
| done_o | output | 1 | One-cycle end pulse |
| fflags_o | output | 4 | Accumulated exception flags |

## Verification
The checks assume VLMAX lies between 1 and MAX_ELEMS, vl does not exceed VLMAX, the rounding mode is one of the five defined codes and the operand ports answer combinationally in the cycle the index is shown. The bench stays inside these limits by sweeping every vl from 0 to VLMAX for two capacities, every combination of mask enable and both policies, with random mask bits, all five modes and random operands whose exponents keep results normal and exact in double precision, so the reference built from real arithmetic is exact before its own rounding step. Directed element sets cover NaNs, infinities, subnormal halves, signed zeros, a rounding tie and overflow, and one run pulses start and alters every configuration input while busy.

// File: rtl/wsub_pkg.sv
package wsub_pkg;

    localparam int WIDE_W   = 32;
    localparam int NARROW_W = 16;
    localparam int FLAG_W   = 4;

    localparam logic [2:0] RM_RNE = 3'd0;
    localparam logic [2:0] RM_RTZ = 3'd1;
    localparam logic [2:0] RM_RDN = 3'd2;
    localparam logic [2:0] RM_RUP = 3'd3;
    localparam logic [2:0] RM_RMM = 3'd4;

    localparam logic [WIDE_W-1:0] QNAN_CANON = 32'h7FC0_0000;

    typedef struct packed {
        logic nv;
        logic of;
        logic uf;
        logic nx;
    } fflags_t;

    function automatic logic [4:0] lead_zeros27(input logic [26:0] v);
        logic [4:0] c;
        logic       hit;
        c   = 5'd27;
        hit = 1'b0;
        for (int i = 26; i >= 0; i--) begin
            if (!hit && v[i]) begin
                c   = 5'(26 - i);
                hit = 1'b1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/wsub_widen.sv
module wsub_widen
    import wsub_pkg::*;
(
    input  logic [NARROW_W-1:0] half_i,
    output logic [WIDE_W-1:0]   single_o
);

    logic        sgn;
    logic [4:0]  hexp;
    logic [9:0]  hman;
    logic [3:0]  msb_pos;
    logic [23:0] norm_man;

    always_comb begin
        sgn     = half_i[15];
        hexp    = half_i[14:10];
        hman    = half_i[9:0];
        msb_pos = '0;
        for (int i = 0; i < 10; i++) begin
            if (hman[i]) msb_pos = 4'(i);
        end
        norm_man = {14'b0, hman} << (5'd23 - {1'b0, msb_pos});

        if (hexp == 5'd0) begin
            if (hman == 10'd0) single_o = {sgn, 31'b0};
            else               single_o = {sgn, 8'({4'b0, msb_pos}) + 8'd103, norm_man[22:0]};
        end else if (hexp == 5'h1F) begin
            single_o = {sgn, 8'hFF, hman, 13'b0};
        end else begin
            single_o = {sgn, {3'b0, hexp} + 8'd112, hman, 13'b0};
        end
    end

    always_comb begin
        if (half_i[14:10] != 5'h1F) begin
            AST_WIDEN_FINITE: assert (single_o[30:23] != 8'hFF); // R2
        end
    end

endmodule

// File: rtl/wsub_fpsub.sv
module wsub_fpsub
    import wsub_pkg::*;
(
    input  logic [WIDE_W-1:0] a_i,
    input  logic [WIDE_W-1:0] b_i,
    input  logic [2:0]        rm_i,
    output logic [WIDE_W-1:0] res_o,
    output fflags_t           flg_o
);

    logic        a_nan, b_nan, a_snan, b_snan, a_inf, b_inf;
    logic        sa, sb, a_big, xs, ys;
    logic [7:0]  ea, eb, xe, ye, dexp;
    logic [23:0] ma, mb, xm, ym;
    logic [26:0] yext, yshift, lost_mask, yal, nrm;
    logic [27:0] sum;
    logic [4:0]  lz, sh;
    logic [8:0]  ef;
    logic [22:0] frac;
    logic [31:0] pk;
    logic        g, rs, inexact, inc, ovf, to_inf;

    always_comb begin
        a_nan  = (&a_i[30:23]) && (|a_i[22:0]);
        b_nan  = (&b_i[30:23]) && (|b_i[22:0]);
        a_snan = a_nan && !a_i[22];
        b_snan = b_nan && !b_i[22];
        a_inf  = (&a_i[30:23]) && !(|a_i[22:0]);
        b_inf  = (&b_i[30:23]) && !(|b_i[22:0]);
        sa     = a_i[31];
        sb     = ~b_i[31];

        ea = (a_i[30:23] == 8'd0) ? 8'd1 : a_i[30:23];
        eb = (b_i[30:23] == 8'd0) ? 8'd1 : b_i[30:23];
        ma = {|a_i[30:23], a_i[22:0]};
        mb = {|b_i[30:23], b_i[22:0]};

        a_big = {ea, ma} >= {eb, mb};
        xs = a_big ? sa : sb;
        xe = a_big ? ea : eb;
        xm = a_big ? ma : mb;
        ys = a_big ? sb : sa;
        ye = a_big ? eb : ea;
        ym = a_big ? mb : ma;

        dexp      = xe - ye;
        yext      = {ym, 3'b0};
        yshift    = yext >> dexp;
        lost_mask = ~({27{1'b1}} << dexp);
        yal       = {yshift[26:1], yshift[0] | (|(yext & lost_mask))};

        if (xs ^ ys) sum = {1'b0, xm, 3'b0} - {1'b0, yal};
        else         sum = {1'b0, xm, 3'b0} + {1'b0, yal};

        lz = lead_zeros27(sum[26:0]);
        sh = '0;
        if (sum[27]) begin
            nrm = {sum[27:2], sum[1] | sum[0]};
            ef  = {1'b0, xe} + 9'd1;
        end else begin
            if ({3'b0, lz} < (xe - 8'd1)) sh = lz;
            else                          sh = 5'(xe - 8'd1);
            nrm = sum[26:0] << sh;
            ef  = {1'b0, xe} - {4'b0, sh};
        end
        if (!nrm[26]) ef = '0;

        frac    = nrm[25:3];
        g       = nrm[2];
        rs      = |nrm[1:0];
        inexact = g | rs;
        case (rm_i)
            RM_RTZ:  inc = 1'b0;
            RM_RDN:  inc = xs & inexact;
            RM_RUP:  inc = ~xs & inexact;
            RM_RMM:  inc = g;
            default: inc = g & (rs | nrm[3]);
        endcase
        case (rm_i)
            RM_RTZ:  to_inf = 1'b0;
            RM_RDN:  to_inf = xs;
            RM_RUP:  to_inf = ~xs;
            default: to_inf = 1'b1;
        endcase

        pk  = {ef, frac} + {31'b0, inc};
        ovf = pk[31:23] >= 9'd255;

        res_o = {xs, pk[30:0]};
        flg_o = '{nv: 1'b0, of: 1'b0, uf: ~nrm[26] & inexact, nx: inexact};
        if (ovf) begin
            res_o = to_inf ? {xs, 8'hFF, 23'b0} : {xs, 8'hFE, 23'h7FFFFF};
            flg_o = '{nv: 1'b0, of: 1'b1, uf: 1'b0, nx: 1'b1};
        end
        if (sum == 28'd0) begin
            res_o = {(sa == sb) ? sa : (rm_i == RM_RDN), 31'b0};
            flg_o = '0;
        end

        if (a_nan || b_nan) begin
            res_o = QNAN_CANON;
            flg_o = '{nv: a_snan | b_snan, of: 1'b0, uf: 1'b0, nx: 1'b0};
        end else if (a_inf && b_inf) begin
            res_o = (sa != sb) ? QNAN_CANON : {sa, 8'hFF, 23'b0};
            flg_o = '{nv: sa != sb, of: 1'b0, uf: 1'b0, nx: 1'b0};
        end else if (a_inf) begin
            res_o = {sa, 8'hFF, 23'b0};
            flg_o = '0;
        end else if (b_inf) begin
            res_o = {sb, 8'hFF, 23'b0};
            flg_o = '0;
        end
    end

    always_comb begin
        if ((&res_o[30:23]) && (|res_o[22:0])) begin
            AST_NAN_CANON: assert (res_o == QNAN_CANON); // R7
        end
        if (res_o[30:0] == 31'd0) begin
            AST_ZERO_EXACT: assert (!flg_o.nx); // R8
        end
    end

endmodule

// File: rtl/wsub_elem_ctl.sv
module wsub_elem_ctl
    import wsub_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0]  idx_i,
    input  logic [CNT_W-1:0]  vl_i,
    input  logic              vm_i,
    input  logic              mbit_i,
    input  logic              vta_i,
    input  logic              vma_i,
    input  logic [WIDE_W-1:0] res_i,
    input  logic [WIDE_W-1:0] old_i,
    input  fflags_t           flg_i,
    output logic [WIDE_W-1:0] data_o,
    output fflags_t           flg_o
);

    logic tail, active, agnostic;

    always_comb begin
        tail     = idx_i >= vl_i;
        active   = !tail && (vm_i || mbit_i);
        agnostic = tail ? vta_i : vma_i;
        if (active)        data_o = res_i;
        else if (agnostic) data_o = '1;
        else               data_o = old_i;
        flg_o = active ? flg_i : '0;
    end

endmodule

// File: rtl/wsub_lane.sv
module wsub_lane
    import wsub_pkg::*;
#(
    parameter int MAX_ELEMS = 16,
    localparam int IDX_W = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [CNT_W-1:0]     vl_i,
    input  logic [CNT_W-1:0]     vlmax_i,
    input  logic                 vm_i,
    input  logic [MAX_ELEMS-1:0] v0_i,
    input  logic                 vta_i,
    input  logic                 vma_i,
    input  logic [2:0]           frm_i,
    output logic [IDX_W-1:0]     rd_idx_o,
    output logic                 rd_vld_o,
    input  logic [WIDE_W-1:0]    vs2_i,
    input  logic [NARROW_W-1:0]  vs1_i,
    input  logic [WIDE_W-1:0]    vd_old_i,
    output logic                 wr_en_o,
    output logic [IDX_W-1:0]     wr_idx_o,
    output logic [WIDE_W-1:0]    wr_data_o,
    output logic                 done_o,
    output logic [FLAG_W-1:0]    fflags_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = 1;
    localparam logic [IDX_W-1:0] IDX_ONE = 1;

    typedef struct packed {
        logic                 busy;
        logic                 last;
        logic [IDX_W-1:0]     idx;
        logic [CNT_W-1:0]     vl;
        logic [CNT_W-1:0]     vlmax;
        logic                 vm;
        logic                 vta;
        logic                 vma;
        logic [2:0]           frm;
        logic [MAX_ELEMS-1:0] mask;
        logic                 wr_en;
        logic [IDX_W-1:0]     wr_idx;
        logic [WIDE_W-1:0]    wr_data;
        logic                 done;
        fflags_t              flags;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic [WIDE_W-1:0] sub_wide;
    logic [WIDE_W-1:0] sub_res;
    fflags_t           sub_flg;
    logic [WIDE_W-1:0] elem_data;
    fflags_t           elem_flg;

    wsub_widen u_widen (
        .half_i   (vs1_i),
        .single_o (sub_wide)
    );

    wsub_fpsub u_fpsub (
        .a_i   (vs2_i),
        .b_i   (sub_wide),
        .rm_i  (st_q.frm),
        .res_o (sub_res),
        .flg_o (sub_flg)
    );

    wsub_elem_ctl #(.CNT_W(CNT_W)) u_ctl (
        .idx_i  ({1'b0, st_q.idx}),
        .vl_i   (st_q.vl),
        .vm_i   (st_q.vm),
        .mbit_i (st_q.mask[st_q.idx]),
        .vta_i  (st_q.vta),
        .vma_i  (st_q.vma),
        .res_i  (sub_res),
        .old_i  (vd_old_i),
        .flg_i  (sub_flg),
        .data_o (elem_data),
        .flg_o  (elem_flg)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = st_q.last;
        st_d.last  = 1'b0;
        if (st_q.busy) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_idx  = st_q.idx;
            st_d.wr_data = elem_data;
            st_d.flags   = st_q.flags | elem_flg;
            if ({1'b0, st_q.idx} == st_q.vlmax - CNT_ONE) begin
                st_d.busy = 1'b0;
                st_d.last = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IDX_ONE;
            end
        end else if (start_i && !st_q.last) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.vl    = vl_i;
            st_d.vlmax = vlmax_i;
            st_d.vm    = vm_i;
            st_d.vta   = vta_i;
            st_d.vma   = vma_i;
            st_d.frm   = frm_i;
            st_d.mask  = v0_i;
            st_d.flags = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_idx_o  = st_q.idx;
    assign rd_vld_o  = st_q.busy;
    assign wr_en_o   = st_q.wr_en;
    assign wr_idx_o  = st_q.wr_idx;
    assign wr_data_o = st_q.wr_data;
    assign done_o    = st_q.done;
    assign fflags_o  = st_q.flags;

    AST_WR_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> $past(st_q.busy)); // R11

    AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> ({1'b0, st_q.idx} < st_q.vlmax)); // R11

    AST_WR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == $past(wr_idx_o) + IDX_ONE)); // R11

    AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(wr_en_o) && ({1'b0, $past(wr_idx_o)} == st_q.vlmax - CNT_ONE))); // R11

    AST_TAIL_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && ({1'b0, wr_idx_o} >= st_q.vl)) |-> (fflags_o == $past(fflags_o))); // R10

    AST_TAIL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && ({1'b0, wr_idx_o} >= st_q.vl) && st_q.vta) |-> (&wr_data_o)); // R5

endmodule

// File: tb/wsub_lane_tb.sv
`timescale 1ns/1ps
module wsub_lane_tb;

    localparam int NE = 8;
    localparam int IW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] vl = '0, vlmax = '0;
    logic          vm = 1'b1, vta = 1'b0, vma = 1'b0;
    logic [NE-1:0] v0 = '0;
    logic [2:0]    frm = '0;
    logic [IW-1:0] rd_idx;
    logic          rd_vld;
    logic [31:0]   vs2, vd_old;
    logic [15:0]   vs1;
    logic          wr_en, done;
    logic [IW-1:0] wr_idx;
    logic [31:0]   wr_data;
    logic [3:0]    fflags;

    logic [31:0] vs2_mem [NE];
    logic [15:0] vs1_mem [NE];
    logic [31:0] vd_mem  [NE];
    logic [31:0] ref_res [NE];
    logic [3:0]  ref_flg [NE];

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    always_comb begin
        vs2    = vs2_mem[rd_idx];
        vs1    = vs1_mem[rd_idx];
        vd_old = vd_mem[rd_idx];
    end

    wsub_lane #(.MAX_ELEMS(NE)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl), .vlmax_i(vlmax),
        .vm_i(vm), .v0_i(v0), .vta_i(vta), .vma_i(vma), .frm_i(frm),
        .rd_idx_o(rd_idx), .rd_vld_o(rd_vld), .vs2_i(vs2), .vs1_i(vs1), .vd_old_i(vd_old),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .done_o(done), .fflags_o(fflags)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    function automatic real s2r(input logic [31:0] a);
        return $bitstoreal({a[31], 11'({3'b0, a[30:23]}) + 11'd896, a[22:0], 29'b0});
    endfunction

    function automatic real h2r(input logic [15:0] h);
        return $bitstoreal({h[15], 11'({6'b0, h[14:10]}) + 11'd1008, h[9:0], 42'b0});
    endfunction

    // reference: exact difference in double precision, then one rounding to single
    task automatic ref_sub(input logic [31:0] a, input logic [15:0] h, input logic [2:0] rm,
                           output logic [31:0] res, output logic [3:0] flg);
        logic [63:0] d;
        logic [30:0] mag;
        logic        s, g, st, up;
        d = $realtobits(s2r(a) - h2r(h));
        s = d[63];
        if (d[62:0] == 63'd0) begin
            res = {rm == 3'd2, 31'b0};
            flg = 4'b0000;
        end else begin
            g  = d[28];
            st = |d[27:0];
            case (rm)
                3'd1:    up = 1'b0;
                3'd2:    up = s & (g | st);
                3'd3:    up = ~s & (g | st);
                3'd4:    up = g;
                default: up = g & (st | d[29]);
            endcase
            mag = {8'(d[62:52] - 11'd896), d[51:29]} + {30'b0, up};
            res = {s, mag};
            flg = {3'b000, g | st};
        end
    endtask

    task automatic run_op(input logic [CW-1:0] l_vl, input logic [CW-1:0] l_vmax,
                          input logic l_vm, input logic l_vta, input logic l_vma,
                          input logic [NE-1:0] l_mask, input logic [2:0] l_rm,
                          input logic poke, input string act_req);
        logic [31:0] exp_d [NE];
        string       req_d [NE];
        logic [3:0]  exp_f;
        exp_f = 4'b0;
        for (int k = 0; k < NE; k++) begin
            logic tail, act;
            tail = k >= int'(l_vl);
            act  = !tail && (l_vm || l_mask[k]);
            if (act) begin
                exp_d[k] = ref_res[k];
                req_d[k] = act_req;
                exp_f    = exp_f | ref_flg[k];
            end else if (tail) begin
                exp_d[k] = l_vta ? 32'hFFFF_FFFF : vd_mem[k];
                req_d[k] = "R5";
            end else begin
                exp_d[k] = l_vma ? 32'hFFFF_FFFF : vd_mem[k];
                req_d[k] = l_vm ? "R3" : "R4";
            end
        end
        @(negedge clk);
        vl = l_vl; vlmax = l_vmax; vm = l_vm; vta = l_vta; vma = l_vma; v0 = l_mask; frm = l_rm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "read valid after start", {31'b0, rd_vld}, 32'd1);
        chk("R11", "no write in first cycle", {31'b0, wr_en}, 32'd0);
        if (poke) begin
            start = 1'b1; vl = '0; vlmax = 4'd1; vm = ~l_vm; vta = ~l_vta; vma = ~l_vma;
            v0 = ~l_mask; frm = 3'd3;
        end
        for (int n = 2; n <= int'(l_vmax) + 2; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (n <= int'(l_vmax) + 1) begin
                chk("R11", "write strobe", {31'b0, wr_en}, 32'd1);
                chk("R11", "write index", {29'b0, wr_idx}, 32'(n - 2));
                chk(req_d[n-2], $sformatf("element %0d data", n - 2), wr_data, exp_d[n-2]);
                chk("R11", "no early done", {31'b0, done}, 32'd0);
            end else begin
                chk("R11", "done pulse", {31'b0, done}, 32'd1);
                chk("R11", "no write with done", {31'b0, wr_en}, 32'd0);
                chk("R10", "accumulated flags", {28'b0, fflags}, {28'b0, exp_f});
            end
        end
        @(negedge clk);
        chk("R11", "done lasts one cycle", {31'b0, done}, 32'd0);
    endtask

    function automatic logic [31:0] rnd_single();
        return {1'($urandom), 8'(120 + $urandom % 16), 23'($urandom)};
    endfunction

    function automatic logic [15:0] rnd_half();
        return {1'($urandom), 5'(10 + $urandom % 11), 10'($urandom)};
    endfunction

    task automatic fill_random(input logic [2:0] rm);
        for (int k = 0; k < NE; k++) begin
            logic [31:0] r;
            logic [3:0]  f;
            vs2_mem[k] = rnd_single();
            vs1_mem[k] = rnd_half();
            vd_mem[k]  = $urandom;
            ref_sub(vs2_mem[k], vs1_mem[k], rm, r, f);
            ref_res[k] = r;
            ref_flg[k] = f;
        end
    endtask

    task automatic set_el(input int k, input logic [31:0] a, input logic [15:0] h,
                          input logic [31:0] r, input logic [3:0] f);
        vs2_mem[k] = a; vs1_mem[k] = h; vd_mem[k] = 32'h1234_0000 + 32'(k);
        ref_res[k] = r; ref_flg[k] = f;
    endtask

    // specials: order, NaNs, infinities, cancellation, overflow
    task automatic load_special(input logic [2:0] rm);
        logic up_ovf;
        up_ovf = (rm == 3'd3);
        set_el(0, 32'h3FC0_0000, 16'h3800, 32'h3F80_0000, 4'b0000);            // R1
        set_el(1, 32'h7F80_0001, 16'h3C00, 32'h7FC0_0000, 4'b1000);            // R7
        set_el(2, 32'h3F80_0000, 16'h7E00, 32'h7FC0_0000, 4'b0000);            // R7
        set_el(3, 32'h3F80_0000, 16'h7C01, 32'h7FC0_0000, 4'b1000);            // R7
        set_el(4, 32'h7F80_0000, 16'h7C00, 32'h7FC0_0000, 4'b1000);            // R7
        set_el(5, 32'h7F80_0000, 16'hFC00, 32'h7F80_0000, 4'b0000);            // R7
        set_el(6, 32'h3F80_0000, 16'h3C00, {rm == 3'd2, 31'b0}, 4'b0000);      // R8
        set_el(7, 32'h7F7F_FFFF, 16'hFBFF,
               up_ovf ? 32'h7F80_0000 : 32'h7F7F_FFFF,
               up_ovf ? 4'b0101 : 4'b0001);                                   // R9
    endtask

    // widening corners and a rounding tie
    task automatic load_widen(input logic [2:0] rm);
        logic tie_up;
        tie_up = (rm == 3'd0) || (rm == 3'd3) || (rm == 3'd4);
        set_el(0, 32'h0000_0000, 16'h0001, 32'hB380_0000, 4'b0000);            // R2
        set_el(1, 32'h8000_0000, 16'h0000, 32'h8000_0000, 4'b0000);            // R8
        set_el(2, 32'h3F80_0000, 16'h03FF, 32'h3F7F_FC01, 4'b0000);            // R2
        set_el(3, 32'h4000_0000, 16'hBC00, 32'h4040_0000, 4'b0000);            // R1
        set_el(4, 32'h3F80_0000, 16'h4000, 32'hBF80_0000, 4'b0000);            // R1
        set_el(5, 32'h0000_0000, 16'h7BFF, 32'hC77F_E000, 4'b0000);            // R2
        set_el(6, 32'h3F80_0000, 16'h0400, 32'h3F7F_FC00, 4'b0000);            // R2
        set_el(7, 32'h4B80_0000, 16'h3800,
               tie_up ? 32'h4B80_0000 : 32'h4B7F_FFFF, 4'b0001);               // R6
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R11 watchdog: actual hung expected done");
        report();
    end

    initial begin
        for (int k = 0; k < NE; k++) begin
            vs2_mem[k] = '0; vs1_mem[k] = '0; vd_mem[k] = '0; ref_res[k] = '0; ref_flg[k] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R11", "reset write strobe", {31'b0, wr_en}, 32'd0);
        chk("R11", "reset done", {31'b0, done}, 32'd0);
        chk("R11", "reset read valid", {31'b0, rd_vld}, 32'd0);
        chk("R10", "reset flags", {28'b0, fflags}, 32'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 5; m++) begin
            load_special(3'(m));
            run_op(4'd8, 4'd8, 1'b1, 1'b0, 1'b0, 8'h00, 3'(m), 1'b0, "R7");
            load_widen(3'(m));
            run_op(4'd8, 4'd8, 1'b1, 1'b0, 1'b0, 8'h00, 3'(m), 1'b0, "R2");
        end

        // flags from masked-off and tail specials must not reach fflags_o
        load_special(3'd3);
        run_op(4'd5, 4'd8, 1'b0, 1'b1, 1'b0, 8'b0000_0101, 3'd3, 1'b0, "R10");

        // start and configuration changes while busy are ignored
        fill_random(3'd1);
        run_op(4'd6, 4'd8, 1'b0, 1'b0, 1'b1, 8'b1010_0110, 3'd1, 1'b1, "R11");

        for (int cap = 0; cap < 2; cap++) begin
            logic [CW-1:0] vmax;
            vmax = (cap == 0) ? 4'd8 : 4'd5;
            for (int l = 0; l <= int'(vmax); l++) begin
                for (int p = 0; p < 8; p++) begin
                    logic [2:0] rm;
                    rm = 3'((l + p + cap) % 5);
                    fill_random(rm);
                    run_op(4'(l), vmax, p[2], p[1], p[0], 8'($urandom), rm, 1'b0, "R6");
                end
            end
        end

        report();
    end

endmodule